// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is a slave-only I2C target that lets an external host read and write a small bank of configuration registers. A fast system clock samples SCL and SDA. The block finds START, repeated START and STOP on the bus. It answers only to a single fixed 7-bit device address. It drives SDA through an output enable that pulls the line low, and it never starts a transfer of its own.

In a write transfer, the first byte after the header sets an internal register pointer. Each byte after that is stored in the register the pointer selects, and the pointer then steps forward. To read, the host sets the pointer the same way, then issues a repeated START with the read header. It then clocks out bytes from successive registers. The pointer wraps from the top entry back to entry zero. The top entry is a hard-wired identification value that ignores writes. All entries are presented to the core logic as one flat parallel bus.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset the SDA output enable is 0. Every bank entry reads 0x00 except entry 0x1B, which reads 0x12. The register pointer is 0x00.
- R2: The target acknowledges header byte 0x88 (7-bit address 0x44, R/W bit 0 = write) and header byte 0x89 (R/W bit 1 = read) by pulling SDA low during the ninth clock. It does not acknowledge any other header, including the general-call byte 0x00. After such a header it leaves SDA released until the next START.
- R3: In a write transfer, the first byte after the header is acknowledged and loaded into the register pointer.
- R4: In a write transfer, each byte after the pointer byte is acknowledged and stored in the entry the pointer selects. The pointer then increments.
- R5: Entry 0x1B always reads 0x12. A data byte aimed at it is acknowledged and discarded, and the pointer still advances.
- R6: The pointer steps from 0x1B to 0x00, in both writes and reads.
- R7: A pointer byte greater than 0x1B selects entry 0x00.
- R8: After a read header, the target returns bytes MSB first from successive entries, starting at the pointer. For each bit it pulls SDA low for a 0 and releases SDA for a 1. It reloads the next byte after each master acknowledge.
- R9: When the master does not acknowledge a read byte, the target releases SDA and drives nothing until the next START.
- R10: A START or repeated START at any point abandons the byte in progress and restarts header reception. A STOP at any point returns the target to idle with SDA released, and a partial data byte is not stored.
- R11: The target changes its SDA drive only while SCL is low.
- R12: Bank entry k appears on bank output bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| bank_o | output | 224 | All register entries, entry k at bits [8k+7:8k] |

## Verification
The target sees an SCL edge two clocks after the pin moves, because of the two synchronizer stages. It registers its reaction on the third clock. An ACK or a read data bit is therefore driven three cycles after the SCL fall that precedes it. The bench holds SCL low for fourteen clocks after each fall and samples the resolved SDA line at the end of the twelve-clock high phase. This leaves a wide margin over that delay. Register contents change three cycles after the SCL fall that ends the eighth bit of a data byte. The bench compares the whole parallel bank against its arithmetic model only after STOP. A monitor flags any change of the SDA drive while the bench holds SCL high.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_END,
    ST_ACK,
    ST_TX,
    ST_TX_ACK
  } eng_state_e;

  typedef enum logic [1:0] {
    KIND_HDR,
    KIND_PTR,
    KIND_DATA
  } byte_kind_e;

endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe_q;
  logic [STAGES-1:0] sda_pipe_q;
  logic              scl_d_q;
  logic              sda_d_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("i2c_line_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_d_q    <= scl_pipe_q[STAGES-1];
      sda_d_q    <= sda_pipe_q[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe_q[STAGES-1];
  assign sda_s     = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d_q;
  assign scl_fall  = ~scl_s & scl_d_q;
  assign start_det = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign stop_det  = scl_s & scl_d_q & ~sda_d_q & sda_s;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int          NUM_REGS = 28,
  parameter int          PTR_W    = 5,
  parameter logic [7:0]  ID_VALUE = 8'h12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [PTR_W-1:0]        wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [PTR_W-1:0]        rd_addr,
  output logic [7:0]              rd_data,
  output logic [NUM_REGS*8-1:0]   bank_o
);

  localparam int LAST = NUM_REGS - 1;

  logic [7:0] ent [NUM_REGS];

  generate
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_ent
      if (gi == LAST) begin : g_id
        assign ent[gi] = ID_VALUE;
      end else begin : g_rw
        logic [7:0] val_q;
        logic       hit;
        assign hit = wr_en && (wr_addr == PTR_W'(gi));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   val_q <= 8'h00;
          else if (hit) val_q <= wr_data;
        end
        assign ent[gi] = val_q;
      end
      assign bank_o[8*gi +: 8] = ent[gi];
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_addr == PTR_W'(k)) rd_data = ent[k];
    end
  end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int         NUM_REGS = 28,
  parameter int         PTR_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [7:0]       wr_data_o,
  output logic [PTR_W-1:0] ptr_o
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_REGS - 1);
  localparam logic [7:0]       LIMIT_B  = 8'(NUM_REGS);

  eng_state_e       state_q, state_d;
  byte_kind_e       kind_q, kind_d;
  logic [2:0]       cnt_q, cnt_d;
  logic [7:0]       sh_q, sh_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             rnw_q, rnw_d;
  logic             oe_q, oe_d;
  logic             mack_q, mack_d;
  logic             wr_en;
  logic [PTR_W-1:0] ptr_inc;
  logic             hdr_hit;

  assign ptr_inc = (ptr_q == LAST_PTR) ? '0 : ptr_q + PTR_W'(1);
  assign hdr_hit = (sh_q[7:1] == DEV_ADDR) && (sh_q[7:1] != 7'h00);

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    rnw_d   = rnw_q;
    oe_d    = oe_q;
    mack_d  = mack_q;
    wr_en   = 1'b0;
    if (start_det) begin
      state_d = ST_RX;
      kind_d  = KIND_HDR;
      cnt_d   = 3'd0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) state_d = ST_RX_END;
          end
        end
        ST_RX_END: begin
          if (scl_fall) begin
            case (kind_q)
              KIND_HDR: begin
                if (hdr_hit) begin
                  oe_d    = 1'b1;
                  rnw_d   = sh_q[0];
                  state_d = ST_ACK;
                end else begin
                  state_d = ST_IDLE;
                end
              end
              KIND_PTR: begin
                ptr_d   = (sh_q < LIMIT_B) ? sh_q[PTR_W-1:0] : '0;
                oe_d    = 1'b1;
                state_d = ST_ACK;
              end
              default: begin
                wr_en   = 1'b1;
                ptr_d   = ptr_inc;
                oe_d    = 1'b1;
                state_d = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_d = 3'd0;
            if (kind_q == KIND_HDR && rnw_q) begin
              sh_d    = rd_data;
              ptr_d   = ptr_inc;
              oe_d    = ~rd_data[7];
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              kind_d  = (kind_q == KIND_HDR) ? KIND_PTR : KIND_DATA;
              state_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              oe_d    = 1'b0;
              state_d = ST_TX_ACK;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              oe_d  = ~sh_q[6];
              cnt_d = cnt_q + 3'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack_d = ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              sh_d    = rd_data;
              ptr_d   = ptr_inc;
              oe_d    = ~rd_data[7];
              cnt_d   = 3'd0;
              state_d = ST_TX;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_HDR;
      cnt_q   <= 3'd0;
      sh_q    <= 8'h00;
      ptr_q   <= '0;
      rnw_q   <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      rnw_q   <= rnw_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en;
  assign wr_data_o = sh_q;
  assign ptr_o     = ptr_q;

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter int         NUM_REGS    = 28,
  parameter logic [7:0] ID_VALUE    = 8'h12,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] bank_o
);

  localparam int PTR_W = $clog2(NUM_REGS);

  logic             rst_core_n;
  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_det;
  logic             stop_det;
  logic             wr_en;
  logic [7:0]       wr_data;
  logic [7:0]       rd_data;
  logic [PTR_W-1:0] cur_ptr;

  i2c_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_byte_engine #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .ptr_o     (cur_ptr)
  );

  cfg_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W),
    .ID_VALUE (ID_VALUE)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_addr (cur_ptr),
    .wr_data (wr_data),
    .rd_addr (cur_ptr),
    .rd_data (rd_data),
    .bank_o  (bank_o)
  );

endmodule

// File: rtl/i2c_cfg_target_chk.sv
module i2c_cfg_target_chk #(
  parameter int NUM_REGS = 28,
  parameter int PTR_W    = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  sda_oe,
  input logic [PTR_W-1:0]      cur_ptr,
  input logic [NUM_REGS*8-1:0] bank
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_REGS - 1);

  // SDA drive only begins in a cycle that follows SCL low
  assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_start_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  assert_ptr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ptr <= LAST_PTR);

  // bank entries only move on a decision taken with SCL low
  assert_bank_update_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank) |-> !$past(scl_s));

endmodule

bind i2c_cfg_target i2c_cfg_target_chk #(
  .NUM_REGS (NUM_REGS),
  .PTR_W    (PTR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe_o),
  .cur_ptr   (cur_ptr),
  .bank      (bank_o)
);

// File: tb/i2c_cfg_target_tb.sv
module i2c_cfg_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 12;
  localparam int NREG       = 28;
  localparam int WATCHDOG   = 190000;

  logic             clk;
  logic             rst_n;
  logic             scl;
  logic             m_sda;
  logic             sda_oe;
  logic             sda_line;
  logic [NREG*8-1:0] bank;

  int checks = 0;
  int errors = 0;
  int mreg [NREG];
  int mptr = 0;
  int oe_viol = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  assign sda_line = m_sda & ~sda_oe;

  i2c_cfg_target u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .bank_o   (bank)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe !== oe_prev)) oe_viol++;
    oe_prev = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int val(input int seed, input int k);
    return (seed * 37 + k * 53 + 11) & 255;
  endfunction

  function automatic int nxt(input int p);
    return (p == NREG - 1) ? 0 : p + 1;
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; scl = 1'b1; tick(HALF);
    m_sda = 1'b0; tick(HALF);
    scl = 1'b0; tick(2);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; tick(HALF);
    scl = 1'b1; tick(HALF);
    m_sda = 1'b0; tick(HALF);
    scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HALF);
    scl = 1'b1; tick(HALF);
    m_sda = 1'b1; tick(HALF);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    m_sda = b; tick(HALF);
    scl = 1'b1; tick(HALF);
    seen = sda_line;
    scl = 1'b0; tick(2);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      v[i] = s;
    end
    clock_bit(~mack, s);
  endtask

  task automatic check_bank(input string tag);
    for (int k = 0; k < NREG; k++)
      chk({tag, " R12 bank entry"}, int'(bank[8*k +: 8]), mreg[k]);
  endtask

  task automatic do_write(input logic [7:0] hdr, input logic [7:0] p,
                          input int n, input int seed, input bit fresh);
    logic a;
    bit   good;
    good = (hdr == 8'h88);
    if (fresh) bus_start(); else bus_rstart();
    wr_byte(hdr, a);
    chk("R2 write header ack", int'(a), int'(good));
    wr_byte(p, a);
    chk("R3 pointer ack", int'(a), int'(good));
    if (good) mptr = (p > 8'd27) ? 0 : int'(p);
    for (int k = 0; k < n; k++) begin
      wr_byte(8'(val(seed, k)), a);
      chk("R4 data ack", int'(a), int'(good));
      if (good) begin
        if (mptr != NREG - 1) mreg[mptr] = val(seed, k);
        mptr = nxt(mptr);
      end
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] p, input int n, input bit setp,
                         input logic [7:0] hdr);
    logic       a;
    logic       s;
    logic [7:0] v;
    bit         good;
    good = (hdr == 8'h89);
    bus_start();
    if (setp) begin
      wr_byte(8'h88, a);
      chk("R2 write header ack", int'(a), 1);
      wr_byte(p, a);
      chk("R3 pointer ack", int'(a), 1);
      mptr = (p > 8'd27) ? 0 : int'(p);
      bus_rstart();
    end
    wr_byte(hdr, a);
    chk("R2 read header ack", int'(a), int'(good));
    if (good) begin
      for (int k = 0; k < n; k++) begin
        rd_byte(k != n - 1, v);
        chk("R8 read data", int'(v), mreg[mptr]);
        mptr = nxt(mptr);
      end
      tick(4);
      chk("R9 release after NACK", int'(sda_oe), 0);
      for (int k = 0; k < 2; k++) begin
        clock_bit(1'b1, s);
        chk("R9 line idle after NACK", int'(s), 1);
      end
    end else begin
      for (int k = 0; k < 8; k++) begin
        clock_bit(1'b1, s);
        chk("R2 no drive after foreign header", int'(s), 1);
      end
    end
    bus_stop();
  endtask

  initial begin
    logic s;
    logic a;
    for (int k = 0; k < NREG; k++) mreg[k] = 0;
    mreg[NREG-1] = 8'h12;
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(6);

    // R1: reset state
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    check_bank("R1 reset");
    do_read(8'h00, 2, 0, 8'h89);

    // R4 R5 R6: full write sweep wrapping past the top entry
    do_write(8'h88, 8'h00, 29, 1, 1);
    check_bank("R4 R5 R6 write sweep");
    do_read(8'h00, 30, 1, 8'h89);
    do_read(8'h1A, 4, 1, 8'h89);

    // R5: write aimed at the ID entry is discarded
    do_write(8'h88, 8'h1B, 2, 2, 1);
    check_bank("R5 id write");

    // R7: out-of-range pointer selects entry 0
    do_write(8'h88, 8'h1E, 1, 3, 1);
    check_bank("R7 pointer clamp");
    do_write(8'h88, 8'hFF, 1, 4, 1);
    check_bank("R7 pointer clamp ff");

    // R2: foreign and general-call headers
    do_write(8'h8A, 8'h02, 2, 5, 1);
    do_write(8'h00, 8'h02, 2, 6, 1);
    do_write(8'h10, 8'h02, 2, 7, 1);
    check_bank("R2 foreign write");
    do_read(8'h00, 1, 0, 8'h8B);

    // R10: repeated START in the middle of a header
    bus_start();
    clock_bit(1'b1, s); clock_bit(1'b0, s); clock_bit(1'b0, s); clock_bit(1'b0, s);
    do_write(8'h88, 8'h05, 2, 8, 0);
    check_bank("R10 restart mid header");

    // R10: STOP in the middle of a data byte stores nothing
    bus_start();
    wr_byte(8'h88, a);
    chk("R10 header ack", int'(a), 1);
    wr_byte(8'h03, a);
    chk("R10 pointer ack", int'(a), 1);
    mptr = 3;
    clock_bit(1'b0, s); clock_bit(1'b1, s); clock_bit(1'b1, s);
    bus_stop();
    tick(4);
    chk("R10 released after STOP", int'(sda_oe), 0);
    check_bank("R10 stop mid data");

    // single-byte write to every entry, then one long read
    for (int p = 0; p < NREG; p++) do_write(8'h88, 8'(p), 1, p + 20, 1);
    check_bank("R4 per-entry sweep");
    do_read(8'h00, NREG, 1, 8'h89);

    chk("R11 drive changed while SCL high", oe_viol, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(WATCHDOG);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule